// File: doc/BRIEF.md
# Packet Error Interrupt Register Block

This block sits between a packet receiver's datapath and a processor bus. The receiver drives a level that stays high from an errored packet until the next packet starts. The block turns that level into a sticky interrupt event. Software clears the event by writing a one to it. A separate enable bit decides whether the event reaches the interrupt line and the summary bit. The event bit keeps recording errors while the enable is off, so software can poll it.

A parameter selects how an event is captured. In edge mode, one flop holds the previous status value, and an event is captured only on a 0-to-1 transition. A status that stays high therefore raises exactly one event, and clearing the event while the status is still high does not raise it again. In level mode, the event is captured on every cycle that the status is high.

The bus side is a plain synchronous port with an address, a write strobe, write data and combinational read data. Each register holds one bit, in bit 0 of its own address.

Top module: `pkt_err_irq_regs`

## Requirements
- R1: After reset, the enable and event bits are 0, `irq_o` is 0, and all four mapped addresses read zero while the status input is low.
- R2: A write to the enable address (default 2) loads write-data bit 0 into the enable bit: 1 enables the interrupt and 0 masks it. The enable bit reads back at bit 0 of that address.
- R3: In edge mode, the event bit sets at the first clock edge where the status is 1 and the stored previous status is 0. A status held high raises no further event after the event is cleared.
- R4: In edge mode, a status that drops low for a single cycle and then rises again raises a new event.
- R5: A write to the event address (default 3) with bit 0 equal to 1 clears the event bit. A write with bit 0 equal to 0 leaves it unchanged.
- R6: When a capture and a clearing write fall in the same cycle, the event bit ends up set.
- R7: `irq_o` and the summary bit (address 0, bit 0) both equal the event bit AND the enable bit. The event bit still sets while the enable bit is 0.
- R8: In level mode, the event bit sets on every clock edge at which the status is 1. A clear issued while the status is high leaves the event set.
- R9: The read map places summary at address 0, raw status at address 1, enable at address 2 and event at address 3, each in bit 0. Bits 31:1 of every read and every read of an unmapped address return zero.
- R10: Writes to the summary address, the status address or an unmapped address change neither the enable bit nor the event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pkt_err_i | input | 1 | Packet-error status level from application logic |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Write strobe, sampled at the rising clock edge |
| reg_wdata_i | input | DATA_W | Write data (only bit 0 is used) |
| reg_rdata_o | output | DATA_W | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request: event AND enable |

## Verification
The bench builds two instances with the default address map and a 32-bit data path. One instance uses `EDGE_MODE=1`, which makes the single-trigger-per-high-period rule, the one-cycle-low re-arm and the clear-versus-capture race reachable. The other uses `EDGE_MODE=0`, which exposes the re-set that follows a clear while the status is still high. A 4-bit address leaves addresses 4 to 15 unmapped, so the bench can check that writes and reads outside the map have no effect.

// File: rtl/pkt_irq_pkg.sv
package pkt_irq_pkg;

   // One-hot-free selector produced by the address decoder
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_SUMMARY,
      SEL_STATUS,
      SEL_ENABLE,
      SEL_EVENT
   } reg_sel_e;

   // Architectural state of the interrupt bit pair
   typedef struct packed {
      logic en;
      logic evt;
   } irq_state_t;

   // True when an address value is representable in the given width
   function automatic bit addr_fits(input int unsigned addr, input int unsigned width);
      return (width >= 32) || (addr < (32'd1 << width));
   endfunction

endpackage

// File: rtl/pkt_irq_decode.sv
module pkt_irq_decode
   import pkt_irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned A_SUMM   = 0,
   parameter int unsigned A_STAT   = 1,
   parameter int unsigned A_ENAB   = 2,
   parameter int unsigned A_EVNT   = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic              wbit_i,
   output reg_sel_e          sel_o,
   output logic              en_wr_o,
   output logic              evt_clr_o
);

   localparam logic [ADDR_W-1:0] SummAddr = ADDR_W'(A_SUMM);
   localparam logic [ADDR_W-1:0] StatAddr = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] EnabAddr = ADDR_W'(A_ENAB);
   localparam logic [ADDR_W-1:0] EvntAddr = ADDR_W'(A_EVNT);

   always_comb begin
      sel_o = SEL_NONE;
      if (addr_i == SummAddr)      sel_o = SEL_SUMMARY;
      else if (addr_i == StatAddr) sel_o = SEL_STATUS;
      else if (addr_i == EnabAddr) sel_o = SEL_ENABLE;
      else if (addr_i == EvntAddr) sel_o = SEL_EVENT;
   end

   // Only the writable bits produce strobes; read-only and unmapped writes vanish here
   assign en_wr_o   = we_i && (sel_o == SEL_ENABLE);
   assign evt_clr_o = we_i && (sel_o == SEL_EVENT) && wbit_i;

endmodule

// File: rtl/pkt_irq_capture.sv
module pkt_irq_capture #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic status_i,
   output logic set_o
);

   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= status_i;
         end

         assign set_o = status_i & ~prev_q;
      end else begin : g_level
         assign set_o = status_i;
      end
   endgenerate

endmodule

// File: rtl/pkt_irq_state.sv
module pkt_irq_state
   import pkt_irq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       set_i,
   input  logic       en_wr_i,
   input  logic       en_wdata_i,
   input  logic       clr_i,
   output irq_state_t state_o
);

   irq_state_t state_q;
   irq_state_t state_d;

   always_comb begin
      state_d = state_q;
      if (en_wr_i) state_d.en = en_wdata_i;
      // Capture has priority over the clearing write
      if (set_i)       state_d.evt = 1'b1;
      else if (clr_i)  state_d.evt = 1'b0;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_q <= '0;
      else         state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/pkt_irq_readmux.sv
module pkt_irq_readmux
   import pkt_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  reg_sel_e          sel_i,
   input  logic              status_i,
   input  irq_state_t        state_i,
   input  logic              summ_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic bit0;

   always_comb begin
      unique case (sel_i)
         SEL_SUMMARY: bit0 = summ_i;
         SEL_STATUS:  bit0 = status_i;
         SEL_ENABLE:  bit0 = state_i.en;
         SEL_EVENT:   bit0 = state_i.evt;
         default:     bit0 = 1'b0;
      endcase
   end

   generate
      if (DATA_W > 1) begin : g_wide
         assign rdata_o = {{(DATA_W-1){1'b0}}, bit0};
      end else begin : g_narrow
         assign rdata_o = bit0;
      end
   endgenerate

endmodule

// File: rtl/pkt_err_irq_regs.sv
module pkt_err_irq_regs
   import pkt_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter bit          EDGE_MODE = 1'b1,
   parameter int unsigned A_SUMM    = 0,
   parameter int unsigned A_STAT    = 1,
   parameter int unsigned A_ENAB    = 2,
   parameter int unsigned A_EVNT    = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pkt_err_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_we_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must hold four distinct addresses");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if (!addr_fits(A_SUMM, ADDR_W) || !addr_fits(A_STAT, ADDR_W) ||
          !addr_fits(A_ENAB, ADDR_W) || !addr_fits(A_EVNT, ADDR_W)) begin : g_bad_fit
         $error("register address does not fit in ADDR_W");
      end
      if (A_SUMM == A_STAT || A_SUMM == A_ENAB || A_SUMM == A_EVNT ||
          A_STAT == A_ENAB || A_STAT == A_EVNT || A_ENAB == A_EVNT) begin : g_bad_map
         $error("register addresses must be distinct");
      end
   endgenerate

   reg_sel_e   sel;
   logic       en_wr;
   logic       evt_clr;
   logic       evt_set;
   irq_state_t state_q;
   logic       en_q;
   logic       ev_q;
   logic       summ;

   generate
      if (DATA_W > 1) begin : g_unused
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:1];
      end
   endgenerate

   pkt_irq_decode #(
      .ADDR_W (ADDR_W),
      .A_SUMM (A_SUMM),
      .A_STAT (A_STAT),
      .A_ENAB (A_ENAB),
      .A_EVNT (A_EVNT)
   ) u_decode (
      .addr_i    (reg_addr_i),
      .we_i      (reg_we_i),
      .wbit_i    (reg_wdata_i[0]),
      .sel_o     (sel),
      .en_wr_o   (en_wr),
      .evt_clr_o (evt_clr)
   );

   pkt_irq_capture #(
      .EDGE_MODE (EDGE_MODE)
   ) u_capture (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .status_i (pkt_err_i),
      .set_o    (evt_set)
   );

   pkt_irq_state u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (evt_set),
      .en_wr_i    (en_wr),
      .en_wdata_i (reg_wdata_i[0]),
      .clr_i      (evt_clr),
      .state_o    (state_q)
   );

   assign en_q  = state_q.en;
   assign ev_q  = state_q.evt;
   assign summ  = en_q & ev_q;
   assign irq_o = summ;

   pkt_irq_readmux #(
      .DATA_W (DATA_W)
   ) u_readmux (
      .sel_i    (sel),
      .status_i (pkt_err_i),
      .state_i  (state_q),
      .summ_i   (summ),
      .rdata_o  (reg_rdata_o)
   );

endmodule

// File: rtl/pkt_irq_chk.sv
module pkt_irq_chk #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter bit          EDGE_MODE = 1'b1,
   parameter int unsigned A_SUMM    = 0,
   parameter int unsigned A_ENAB    = 2,
   parameter int unsigned A_EVNT    = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              status_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              we_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [DATA_W-1:0] rdata_i,
   input logic              irq_i,
   input logic              en_q,
   input logic              ev_q,
   input logic              set_i
);

   logic clr_wr;
   logic en_wr;
   assign clr_wr = we_i && (addr_i == ADDR_W'(A_EVNT)) && wdata_i[0];
   assign en_wr  = we_i && (addr_i == ADDR_W'(A_ENAB));

   // R7
   summary_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == ADDR_W'(A_SUMM)) |-> (rdata_i == DATA_W'(irq_i)));

   // R6
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && clr_wr) |=> ev_q);

   // R5
   clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_wr && !set_i) |=> !ev_q);

   // R10
   enable_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_wr |=> $stable(en_q));

   // R2
   enable_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_wr |=> (en_q == $past(wdata_i[0])));

   generate
      if (EDGE_MODE) begin : g_edge
         // R3
         edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_i && !$past(status_i)) |=> ev_q);
         // R3
         held_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (status_i && $past(status_i) && !ev_q) |=> !ev_q);
      end else begin : g_level
         // R8
         level_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            status_i |=> ev_q);
      end
   endgenerate

endmodule

bind pkt_err_irq_regs pkt_irq_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .EDGE_MODE (EDGE_MODE),
   .A_SUMM    (A_SUMM),
   .A_ENAB    (A_ENAB),
   .A_EVNT    (A_EVNT)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .status_i (pkt_err_i),
   .addr_i   (reg_addr_i),
   .we_i     (reg_we_i),
   .wdata_i  (reg_wdata_i),
   .rdata_i  (reg_rdata_o),
   .irq_i    (irq_o),
   .en_q     (en_q),
   .ev_q     (ev_q),
   .set_i    (evt_set)
);

// File: tb/pkt_err_irq_regs_bench.sv
module pkt_err_irq_regs_bench;

   localparam int AW = 4;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          e_status = 1'b0, e_we = 1'b0, e_irq;
   logic [AW-1:0] e_addr = '0;
   logic [DW-1:0] e_wdata = '0, e_rdata;
   logic          l_status = 1'b0, l_we = 1'b0, l_irq;
   logic [AW-1:0] l_addr = '0;
   logic [DW-1:0] l_wdata = '0, l_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   pkt_err_irq_regs #(.ADDR_W(AW), .DATA_W(DW), .EDGE_MODE(1'b1)) u_pkt_err_irq_regs (
      .clk_i(clk), .rst_ni(rst_n), .pkt_err_i(e_status), .reg_addr_i(e_addr),
      .reg_we_i(e_we), .reg_wdata_i(e_wdata), .reg_rdata_o(e_rdata), .irq_o(e_irq));

   pkt_err_irq_regs #(.ADDR_W(AW), .DATA_W(DW), .EDGE_MODE(1'b0)) u_pkt_err_irq_regs_lvl (
      .clk_i(clk), .rst_ni(rst_n), .pkt_err_i(l_status), .reg_addr_i(l_addr),
      .reg_we_i(l_we), .reg_wdata_i(l_wdata), .reg_rdata_o(l_rdata), .irq_o(l_irq));

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic e_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      e_addr = a; e_we = 1'b1; e_wdata = d;
      tick();
      e_we = 1'b0; e_wdata = '0;
   endtask

   task automatic e_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      e_addr = a;
      #1;
      d = e_rdata;
   endtask

   task automatic l_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      l_addr = a; l_we = 1'b1; l_wdata = d;
      tick();
      l_we = 1'b0; l_wdata = '0;
   endtask

   task automatic l_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      l_addr = a;
      #1;
      l_rdata_hold = l_rdata;
      d = l_rdata_hold;
   endtask
   logic [DW-1:0] l_rdata_hold;

   task automatic t_reset();
      logic [DW-1:0] v;
      for (int a = 0; a < 4; a++) begin
         e_rd(AW'(a), v);
         check("R1 reset read", v, '0);
      end
      check("R1 reset irq", DW'(e_irq), '0);
   endtask

   task automatic t_enable();
      logic [DW-1:0] v;
      e_wr(4'd2, 32'h0000_0001);
      e_rd(4'd2, v);
      check("R2 enable set", v, 32'd1);
      e_wr(4'd2, 32'hFFFF_FFFE);
      e_rd(4'd2, v);
      check("R2 enable masked by bit0=0", v, 32'd0);
   endtask

   task automatic t_edge_masked();
      logic [DW-1:0] v;
      e_status = 1'b1;
      tick();
      e_rd(4'd3, v);
      check("R3 edge captured", v, 32'd1);
      check("R7 masked irq low", DW'(e_irq), '0);
      e_rd(4'd0, v);
      check("R7 masked summary low", v, 32'd0);
      e_wr(4'd3, 32'd1);
      tick();
      e_rd(4'd3, v);
      check("R3 held status no re-set", v, 32'd0);
   endtask

   task automatic t_back_to_back();
      logic [DW-1:0] v;
      e_status = 1'b0;
      tick();
      e_status = 1'b1;
      tick();
      e_rd(4'd3, v);
      check("R4 re-arm after one low cycle", v, 32'd1);
      e_wr(4'd2, 32'd1);
      check("R7 irq when enabled", DW'(e_irq), 32'd1);
      e_rd(4'd0, v);
      check("R7 summary when enabled", v, 32'd1);
      e_wr(4'd3, 32'hFFFF_FFFE);
      e_rd(4'd3, v);
      check("R5 write zero keeps event", v, 32'd1);
   endtask

   task automatic t_set_wins();
      logic [DW-1:0] v;
      e_status = 1'b0;
      e_wr(4'd3, 32'd1);
      e_rd(4'd3, v);
      check("R5 clear by write one", v, 32'd0);
      e_status = 1'b1;
      e_wr(4'd3, 32'd1);
      e_rd(4'd3, v);
      check("R6 capture beats clear", v, 32'd1);
   endtask

   task automatic t_map();
      logic [DW-1:0] v;
      e_rd(4'd1, v);
      check("R9 status readback high", v, 32'd1);
      e_rd(4'd7, v);
      check("R9 unmapped reads zero", v, 32'd0);
      e_wr(4'd0, 32'hFFFF_FFFF);
      e_wr(4'd1, 32'h0000_0000);
      e_wr(4'd9, 32'h0000_0000);
      e_rd(4'd2, v);
      check("R10 enable untouched", v, 32'd1);
      e_rd(4'd3, v);
      check("R10 event untouched", v, 32'd1);
      e_status = 1'b0;
      e_rd(4'd1, v);
      check("R9 status readback low", v, 32'd0);
   endtask

   task automatic t_level();
      logic [DW-1:0] v;
      l_rd(4'd3, v);
      check("R1 level reset event", v, 32'd0);
      l_status = 1'b1;
      tick();
      l_rd(4'd3, v);
      check("R8 level capture", v, 32'd1);
      l_wr(4'd3, 32'd1);
      l_rd(4'd3, v);
      check("R8 clear while high re-sets", v, 32'd1);
      l_status = 1'b0;
      l_wr(4'd3, 32'd1);
      l_rd(4'd3, v);
      check("R8 clear after status low", v, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_edge_masked();
      t_back_to_back();
      t_set_wins();
      t_map();
      t_level();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule